// File: doc/BRIEF.md
# Instruction Line Alignment Buffer

This block sits between instruction fetch and dispatch. Fetch delivers 128-bit lines, and each line holds four 32-bit instruction slots. The buffer queues up to five such lines. It then cuts the instruction stream into execution groups of one to four instructions. A group may begin at any slot of a line and may run on into the following line, so code needs no alignment in memory.

Each complete group is packed into slots 0 upward of a single output line. A 4-bit mask marks the occupied slots, and dispatch takes the group with a valid/ready handshake. Fetch is held off through a ready signal when the queue is full. A flush, used on a taken branch, empties the queue in one cycle. It also sets the slot offset at which reading resumes in the next fetched line.

Top module: `insn_align_buf`

## Requirements
- R1: After reset, `grp_valid_o` is low and `fetch_ready_o` is high.
- R2: At most five fetched lines are held. With five held and no line retired in the current cycle, `fetch_ready_o` is low and the presented line is not taken.
- R3: When five lines are held and the group accepted this cycle retires the oldest line, `fetch_ready_o` is high in that same cycle and a presented line is taken.
- R4: A group ends at the first instruction whose bit 31 is 1, or at its fourth instruction, whichever comes first. Its n instructions occupy output slots 0..n-1 (slot k at bits 32k+31:32k), `grp_mask_o` has bits 0..n-1 set, and unused slots read zero.
- R5: A group that starts late in one fetched line and ends in the next line is presented as one contiguous output group.
- R6: `grp_valid_o` is high only when every instruction of the group, up to and including its ending instruction, is buffered.
- R7: Groups reach dispatch in program order, with no instruction skipped or repeated.
- R8: With `flush_i` high, the queue is emptied at the clock edge, `grp_valid_o` and `fetch_ready_o` are low, and the first group after the flush starts at slot `flush_slot_i` (0..3) of the next accepted line.
- R9: While `grp_valid_o` is high and `grp_ready_i` is low, the presented group and mask stay unchanged in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetched line present |
| fetch_line_i | input | 128 | Fetched line, slot k at bits 32k+31:32k |
| fetch_ready_o | output | 1 | Buffer takes the fetched line this cycle |
| flush_i | input | 1 | Empty the buffer (branch redirect) |
| flush_slot_i | input | 2 | Slot offset of the branch target in the next line |
| grp_valid_o | output | 1 | Complete execution group presented |
| grp_ready_i | input | 1 | Dispatch takes the group |
| grp_line_o | output | 128 | Packed group, unused slots zero |
| grp_mask_o | output | 4 | Occupied output slots |

## Verification
Streams made only of end-marked instructions produce one-instruction groups. These show that the read offset steps through every slot position. Streams with no end marks produce forced four-instruction groups, which cross a line boundary at every offset except zero. Random end-mark densities, combined with random fetch gaps and dispatch stalls, separate a group that is really complete from one still waiting on its next line. Directed fill-and-drain sequences and flushes to each target slot separate the full-queue hold-off from the same-cycle refill and the post-branch restart offset.

// File: rtl/insn_align_pkg.sv
package insn_align_pkg;
  localparam int SLOTS   = 4;
  localparam int INSN_W  = 32;
  localparam int LINE_W  = SLOTS * INSN_W;
  localparam int OFF_W   = $clog2(SLOTS);
  localparam int EOG_BIT = INSN_W - 1;
  typedef logic [INSN_W-1:0] insn_t;
endpackage

// File: rtl/insn_align_store.sv
module insn_align_store
  import insn_align_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              pop_i,
  output logic [LINE_W-1:0] head_o,
  output logic [LINE_W-1:0] next_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LINE_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q, rd_nx;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign rd_nx  = inc(rd_q);
  assign head_o = mem_q[rd_q];
  assign next_o = mem_q[rd_nx];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_q] <= line_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= inc(wr_q);
      if (pop_i)  rd_q <= rd_nx;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/insn_align_window.sv
module insn_align_window
  import insn_align_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [LINE_W-1:0] head_i,
  input  logic [LINE_W-1:0] next_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic              valid_o,
  output logic [LINE_W-1:0] line_o,
  output logic [SLOTS-1:0]  mask_o,
  output logic              pop_o,
  output logic [OFF_W-1:0]  off_nx_o
);
  insn_t            win_w [SLOTS];
  logic [SLOTS-1:0] win_p;
  logic [OFF_W:0]   n_q;
  logic             ok;
  logic [OFF_W:0]   end_idx;

  // window slot j = stream position off_i + j, spilling into the next line
  for (genvar j = 0; j < SLOTS; j++) begin : g_win
    logic [OFF_W:0] idx;
    assign idx = {1'b0, off_i} + (OFF_W + 1)'(j);
    assign win_w[j] = idx[OFF_W] ? next_i[idx[OFF_W-1:0]*INSN_W +: INSN_W]
                                 : head_i[idx[OFF_W-1:0]*INSN_W +: INSN_W];
    assign win_p[j] = idx[OFF_W] ? (cnt_i >= CNT_W'(2)) : (cnt_i >= CNT_W'(1));
    assign mask_o[j] = ok && ((OFF_W + 1)'(j) < n_q);
    assign line_o[j*INSN_W +: INSN_W] = mask_o[j] ? win_w[j] : '0;
  end

  always_comb begin
    logic done;
    done = 1'b0;
    ok   = 1'b0;
    n_q  = '0;
    for (int j = 0; j < SLOTS; j++) begin
      if (!done) begin
        if (!win_p[j]) begin
          done = 1'b1;
        end else begin
          n_q = (OFF_W + 1)'(j + 1);
          if (win_w[j][EOG_BIT] || j == SLOTS - 1) begin
            ok   = 1'b1;
            done = 1'b1;
          end
        end
      end
    end
  end

  assign end_idx  = {1'b0, off_i} + n_q;
  assign valid_o  = ok;
  assign pop_o    = ok && end_idx[OFF_W];
  assign off_nx_o = end_idx[OFF_W-1:0];
endmodule

// File: rtl/insn_align_buf.sv
module insn_align_buf
  import insn_align_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [LINE_W-1:0] fetch_line_i,
  output logic              fetch_ready_o,
  input  logic              flush_i,
  input  logic [OFF_W-1:0]  flush_slot_i,
  output logic              grp_valid_o,
  input  logic              grp_ready_i,
  output logic [LINE_W-1:0] grp_line_o,
  output logic [SLOTS-1:0]  grp_mask_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [LINE_W-1:0] head, next;
  logic [CNT_W-1:0]  cnt;
  logic [OFF_W-1:0]  off_q, off_nx;
  logic              win_valid, win_pop, fire, pop, push;

  assign grp_valid_o   = win_valid && !flush_i;
  assign fire          = grp_valid_o && grp_ready_i;
  assign pop           = fire && win_pop;
  // a retiring line frees its entry for the incoming one in the same cycle
  assign fetch_ready_o = !flush_i && ((cnt < CNT_W'(DEPTH)) || pop);
  assign push          = fetch_valid_i && fetch_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      off_q <= '0;
    else if (flush_i) off_q <= flush_slot_i;
    else if (fire)    off_q <= off_nx;
  end

  insn_align_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush_i),
    .push_i (push),
    .line_i (fetch_line_i),
    .pop_i  (pop),
    .head_o (head),
    .next_o (next),
    .cnt_o  (cnt)
  );

  insn_align_window #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_window (
    .head_i  (head),
    .next_i  (next),
    .cnt_i   (cnt),
    .off_i   (off_q),
    .valid_o (win_valid),
    .line_o  (grp_line_o),
    .mask_o  (grp_mask_o),
    .pop_o   (win_pop),
    .off_nx_o(off_nx)
  );
endmodule

// File: rtl/insn_align_buf_chk.sv
module insn_align_buf_chk
  import insn_align_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_ready_o,
  input logic              flush_i,
  input logic              grp_valid_o,
  input logic              grp_ready_i,
  input logic [LINE_W-1:0] grp_line_o,
  input logic [SLOTS-1:0]  grp_mask_o,
  input logic [CNT_W-1:0]  cnt_i
);
  logic [LINE_W-1:0] unused_bits;
  logic              end_ok;

  for (genvar j = 0; j < SLOTS; j++) begin : g_bits
    assign unused_bits[j*INSN_W +: INSN_W] = grp_mask_o[j] ? '0 : grp_line_o[j*INSN_W +: INSN_W];
  end

  always_comb begin
    end_ok = 1'b1;
    for (int j = 0; j < SLOTS; j++) begin
      if (grp_mask_o[j]) begin
        if (j < SLOTS - 1 && !grp_mask_o[j+1]) begin
          if (!grp_line_o[j*INSN_W + EOG_BIT]) end_ok = 1'b0;
        end else if (j < SLOTS - 1) begin
          if (grp_line_o[j*INSN_W + EOG_BIT]) end_ok = 1'b0;
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH)); // R2

  AST_FULL_HOLDS_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_W'(DEPTH) && !(grp_valid_o && grp_ready_i)) |-> !fetch_ready_o); // R2

  AST_MASK_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> (grp_mask_o == 4'b0001 || grp_mask_o == 4'b0011 ||
                     grp_mask_o == 4'b0111 || grp_mask_o == 4'b1111)); // R4

  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> unused_bits == '0); // R4

  AST_GROUP_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> end_ok); // R4

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_i == '0 && !grp_valid_o)); // R8

  AST_FLUSH_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !fetch_ready_o && !grp_valid_o); // R8

  AST_STALL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_valid_o && !grp_ready_i && !flush_i) |=>
      (flush_i || (grp_valid_o && $stable(grp_line_o) && $stable(grp_mask_o)))); // R9
endmodule

bind insn_align_buf insn_align_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_ready_o(fetch_ready_o),
  .flush_i      (flush_i),
  .grp_valid_o  (grp_valid_o),
  .grp_ready_i  (grp_ready_i),
  .grp_line_o   (grp_line_o),
  .grp_mask_o   (grp_mask_o),
  .cnt_i        (cnt)
);

// File: tb/tb_insn_align_buf.sv
`timescale 1ns/1ps
module tb_insn_align_buf;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fetch_valid_i = 1'b0;
  logic [127:0] fetch_line_i = '0;
  logic         fetch_ready_o;
  logic         flush_i = 1'b0;
  logic [1:0]   flush_slot_i = '0;
  logic         grp_valid_o;
  logic         grp_ready_i = 1'b0;
  logic [127:0] grp_line_o;
  logic [3:0]   grp_mask_o;

  int total = 0;
  int fails = 0;

  logic [31:0] q[$];
  int          m_off = 0;
  bit          prev_flush = 0;
  bit          prev_stall = 0;

  always #5 clk = ~clk;

  insn_align_buf dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fetch_valid_i), .fetch_line_i(fetch_line_i), .fetch_ready_o(fetch_ready_o),
    .flush_i(flush_i), .flush_slot_i(flush_slot_i),
    .grp_valid_o(grp_valid_o), .grp_ready_i(grp_ready_i),
    .grp_line_o(grp_line_o), .grp_mask_o(grp_mask_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_line(input int eog_pct);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) begin
      l[k*32 +: 31] = 31'($urandom);
      l[k*32 + 31]  = (($urandom % 100) < eog_pct);
    end
    return l;
  endfunction

  task automatic step(input logic fv, input logic [127:0] ln, input logic ordy,
                      input logic fl, input logic [1:0] fs);
    bit           exp_ok, stop, pop, exp_rdy, straddle;
    int           exp_n, lines;
    logic [127:0] exp_line;
    logic [3:0]   exp_mask;
    string        tag;
    @(negedge clk);
    fetch_valid_i = fv; fetch_line_i = ln; grp_ready_i = ordy;
    flush_i = fl; flush_slot_i = fs;
    #1;
    exp_ok = 0; exp_n = 0; stop = 0;
    for (int j = 0; j < 4; j++) begin
      if (!stop) begin
        if (m_off + j >= q.size()) stop = 1;
        else begin
          exp_n = j + 1;
          if (q[m_off+j][31] || j == 3) begin exp_ok = 1; stop = 1; end
        end
      end
    end
    if (fl) exp_ok = 0;
    exp_line = '0; exp_mask = '0;
    if (exp_ok)
      for (int j = 0; j < exp_n; j++) begin
        exp_line[j*32 +: 32] = q[m_off+j];
        exp_mask[j] = 1'b1;
      end
    straddle = exp_ok && (m_off + exp_n > 4);
    lines    = q.size() / 4;
    pop      = exp_ok && ordy && (m_off + exp_n >= 4);
    exp_rdy  = !fl && (lines < 5 || pop);

    tag = prev_flush ? "R8" : (fl ? "R8" : "R6");
    chk(grp_valid_o == exp_ok, {tag, " valid"}, 128'(grp_valid_o), 128'(exp_ok));
    if (exp_ok && grp_valid_o) begin
      chk(grp_mask_o == exp_mask, "R4 mask", 128'(grp_mask_o), 128'(exp_mask));
      tag = straddle ? "R5" : (prev_stall ? "R9" : "R7");
      chk(grp_line_o == exp_line, {tag, " line"}, grp_line_o, exp_line);
    end
    tag = fl ? "R8" : ((lines == 5 && pop) ? "R3" : "R2");
    chk(fetch_ready_o == exp_rdy, {tag, " ready"}, 128'(fetch_ready_o), 128'(exp_rdy));

    if (fl) begin
      q.delete();
      m_off = fs;
    end else begin
      if (exp_ok && ordy) begin
        if (pop) repeat (4) void'(q.pop_front());
        m_off = (m_off + exp_n) % 4;
      end
      if (fv && exp_rdy)
        for (int k = 0; k < 4; k++) q.push_back(ln[k*32 +: 32]);
    end
    prev_flush = fl;
    prev_stall = exp_ok && !ordy;
    @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R7 watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(posedge clk);
    #1;
    chk(grp_valid_o == 1'b0, "R1 valid after reset", 128'(grp_valid_o), 128'd0);
    rst_n = 1'b1;
    #2;
    chk(grp_valid_o == 1'b0, "R1 valid idle", 128'(grp_valid_o), 128'd0);
    chk(fetch_ready_o == 1'b1, "R1 ready idle", 128'(fetch_ready_o), 128'd1);

    // single-instruction groups across every offset
    for (int i = 0; i < 3; i++) step(1, mk_line(100), 1, 0, 0);
    repeat (14) step(0, '0, 1, 0, 0);
    // forced four-wide groups, straddling after a flush to slot 1 (R5)
    step(0, '0, 0, 1, 2'd1);
    for (int i = 0; i < 3; i++) step(1, mk_line(0), 1, 0, 0);
    repeat (6) step(0, '0, 1, 0, 0);
    // fill to capacity with dispatch stalled (R2, R9)
    for (int i = 0; i < 7; i++) step(1, mk_line(30), 0, 0, 0);
    // drain while fetch keeps pushing: refill on retire (R3)
    for (int i = 0; i < 20; i++) step(1, mk_line(30), 1, 0, 0);
    // flush to each target slot (R8)
    for (int s = 0; s < 4; s++) begin
      step(1, mk_line(50), 1, 1, 2'(s));
      step(1, mk_line(50), 1, 0, 0);
      step(1, mk_line(50), 1, 0, 0);
      repeat (3) step(0, '0, 1, 0, 0);
    end
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int pct;
      pct = (i / 500) % 4 == 0 ? 0 : ((i / 500) % 4 == 1 ? 100 : 35);
      step(($urandom % 100) < 70, mk_line(pct), ($urandom % 100) < 60,
           ($urandom % 60) == 0, 2'($urandom));
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule